// File: doc/BRIEF.md
# Integer-N Synthesizer Latch Loader

This block sets up a three-latch integer-N frequency synthesizer from a requested feedback divide value. When `start` is pulsed, it splits the divide value into the two counters of an 8/9 dual-modulus prescaler: the main count B and the swallow count A. Values the prescaler cannot reach are refused at once, and nothing is sent on the serial bus. A reachable value produces three 24-bit latch words: reference, control and divider. Each word goes out as its own frame on a write-only three-wire serial link.

On the first load after reset only, the block holds off the divider frame for roughly 10 ms. This gives the synthesizer core time to settle after it is powered up. The hold-off is counted in system clocks and derived from the `CLK_HZ` parameter. Later loads send the divider frame as soon as the control frame ends.

Each request finishes with a one-cycle `done` pulse. The `error` flag tells whether that request was refused. The lock indicator from the synthesizer is an asynchronous, active-high pin. It passes through a two-stage synchronizer and comes out as `lock_sts`.

Top module: `pll_synth_loader`

## Requirements
- R1: With B = N div 8 and A = N mod 8, a request where B < A sends no frame. At the end of such a request, `done` pulses and `error` goes to 1. `error` is held until the next accepted request clears it to 0.
- R2: The reference frame carries exactly 0x340041: address 01 in bits [1:0], divider 16 in [15:2], lock precision 1 in bit 18 and band select 3 in [21:20].
- R3: The control frame carries CP2 in [19:17] and CP1 in [16:14]. The bits 0x000924 are always set: core power 1 in [3:2], mux select 1 in [7:5], polarity bit 8 and mute bit 11. All other bits, including address 00 in [1:0], are zero.
- R4: The divider frame carries address 10 in [1:0], A in [6:2], B from bit 8 upward and DIV2 in bit 22. Bits 21 and 23 are zero.
- R5: An accepted request sends three frames in the order reference, control, divider. Each frame is 24 bits, MSB first, framed by `spi_sen_n` held low. `spi_sdata` changes only while `spi_sclk` falls or is low, and it is sampled on the rising edge. `spi_sclk` is high only while `spi_sen_n` is low.
- R6: Between any two frames, `spi_sen_n` stays high for at least one clock cycle.
- R7: The first accepted load after reset leaves at least CLK_HZ/100 cycles between the end of the control frame and the start of the divider frame. Later loads leave fewer. Refused requests do not use up the hold-off. A new reset arms it again.
- R8: `busy` is high from the cycle after an accepted start until `done`. `done` lasts exactly one cycle, and `busy` falls only together with `done`. A `start` that arrives while `busy` is high is ignored, together with its inputs.
- R9: `lock_sts` follows `lock_pin` two clock edges later.
- R10: After reset: `busy`, `done`, `error`, `spi_sclk`, `spi_sdata` and `lock_sts` are 0, and `spi_sen_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to load the synthesizer |
| n_div | input | 16 | Requested feedback divide value |
| div2 | input | 1 | Per-board divide-by-2 flag for the divider frame |
| cp1 | input | 3 | Charge-pump current setting 1 |
| cp2 | input | 3 | Charge-pump current setting 2 |
| lock_pin | input | 1 | Asynchronous lock indicator from the synthesizer |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle pulse at the end of each request |
| error | output | 1 | Last request was refused as unreachable |
| lock_sts | output | 1 | Synchronized lock indicator |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_sen_n | output | 1 | Frame enable, active low |
| spi_sdata | output | 1 | Serial data |

## Verification
The assertions assume that `start` is a plain synchronous pulse. They also assume that `n_div`, `div2` and the charge-pump inputs are stable on the edge where `start` is high, and that `lock_pin` is held low during reset. The bench drives every input just after a rising edge and lowers `start` before the next edge. It holds `lock_pin` at 0 through each reset. It sweeps every divide value from 0 to 255, which covers both sides of the B < A boundary, and adds the largest divide values. It also pulses `start` in the middle of a load with different inputs, to check that the request is ignored.

// File: rtl/pll_ld_pkg.sv
package pll_ld_pkg;

    localparam int LATCH_W  = 24;
    localparam int PSC_LOG2 = 3;
    localparam int N_W      = 16;
    localparam int A_W      = PSC_LOG2;
    localparam int B_W      = N_W - PSC_LOG2;
    localparam int CUR_W    = 3;

    localparam logic [1:0]  ADDR_REF  = 2'b01;
    localparam logic [1:0]  ADDR_NDIV = 2'b10;
    localparam logic [1:0]  ADDR_CTL  = 2'b00;
    localparam logic [13:0] REF_DIV   = 14'd16;
    localparam logic [1:0]  BAND_SEL  = 2'd3;
    localparam logic [2:0]  MUX_SEL   = 3'd1;
    localparam logic [1:0]  CORE_PWR  = 2'd1;

    typedef logic [LATCH_W-1:0] latch_t;

    typedef struct packed {
        logic           ok;
        logic [B_W-1:0] b;
        logic [A_W-1:0] a;
    } split_t;

    typedef enum logic [1:0] {FRM_REF, FRM_CTL, FRM_NDIV} frame_e;
    typedef enum logic [1:0] {LD_IDLE, LD_SEND, LD_SETTLE} ld_state_e;
    typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_GAP} sh_state_e;

    function automatic latch_t ref_word();
        latch_t w;
        w        = '0;
        w[1:0]   = ADDR_REF;
        w[15:2]  = REF_DIV;
        w[18]    = 1'b1;
        w[21:20] = BAND_SEL;
        return w;
    endfunction

    function automatic latch_t ctl_word(input logic [CUR_W-1:0] c1,
                                        input logic [CUR_W-1:0] c2);
        latch_t w;
        w        = '0;
        w[1:0]   = ADDR_CTL;
        w[3:2]   = CORE_PWR;
        w[7:5]   = MUX_SEL;
        w[8]     = 1'b1;
        w[11]    = 1'b1;
        w[16:14] = c1;
        w[19:17] = c2;
        return w;
    endfunction

    function automatic latch_t ndiv_word(input logic [A_W-1:0] a,
                                         input logic [B_W-1:0] b,
                                         input logic           d2);
        latch_t w;
        w            = '0;
        w[1:0]       = ADDR_NDIV;
        w[6:2]       = {{(5-A_W){1'b0}}, a};
        w[8 +: B_W]  = b;
        w[22]        = d2;
        return w;
    endfunction

endpackage

// File: rtl/pll_ld_split.sv
module pll_ld_split
    import pll_ld_pkg::*;
(
    input  logic [N_W-1:0] n_div,
    output split_t         res
);
    logic [B_W-1:0] b_cnt;
    logic [A_W-1:0] a_cnt;

    always_comb begin
        b_cnt  = n_div[N_W-1:PSC_LOG2];
        a_cnt  = n_div[PSC_LOG2-1:0];
        res.b  = b_cnt;
        res.a  = a_cnt;
        res.ok = ({{(B_W-A_W){1'b0}}, a_cnt} <= b_cnt);
    end
endmodule

// File: rtl/pll_ld_shift.sv
module pll_ld_shift
    import pll_ld_pkg::*;
#(
    parameter int W        = 24,
    parameter int HALF_CYC = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] word,
    output logic         sclk,
    output logic         sen_n,
    output logic         sdata,
    output logic         fin
);
    localparam int PH_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int BC_W = $clog2(W);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF_CYC - 1);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(W - 1);

    sh_state_e       st;
    logic [W-1:0]    sr;
    logic [PH_W-1:0] ph;
    logic [BC_W-1:0] bc;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SH_IDLE;
            sr    <= '0;
            ph    <= '0;
            bc    <= '0;
            sclk  <= 1'b0;
            sen_n <= 1'b1;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            case (st)
                SH_IDLE: begin
                    if (load) begin
                        sr    <= word;
                        sen_n <= 1'b0;
                        sclk  <= 1'b0;
                        ph    <= '0;
                        bc    <= '0;
                        st    <= SH_SHIFT;
                    end
                end
                SH_SHIFT: begin
                    if (ph == PH_LAST) begin
                        ph   <= '0;
                        sclk <= ~sclk;
                        if (sclk) begin
                            if (bc == BC_LAST) begin
                                sen_n <= 1'b1;
                                st    <= SH_GAP;
                            end else begin
                                sr <= {sr[W-2:0], 1'b0};
                                bc <= bc + 1'b1;
                            end
                        end
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                SH_GAP: begin
                    if (ph == PH_LAST) begin
                        ph  <= '0;
                        fin <= 1'b1;
                        st  <= SH_IDLE;
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                default: st <= SH_IDLE;
            endcase
        end
    end

    assign sdata = (st == SH_SHIFT) ? sr[W-1] : 1'b0;
endmodule

// File: rtl/pll_ld_sync.sv
module pll_ld_sync (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) stage <= 2'b00;
        else     stage <= {stage[0], din};
    end

    assign dout = stage[1];
endmodule

// File: rtl/pll_synth_loader.sv
module pll_synth_loader
    import pll_ld_pkg::*;
#(
    parameter int CLK_HZ    = 100_000_000,
    parameter int SCLK_HALF = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [N_W-1:0]   n_div,
    input  logic             div2,
    input  logic [CUR_W-1:0] cp1,
    input  logic [CUR_W-1:0] cp2,
    input  logic             lock_pin,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic             lock_sts,
    output logic             spi_sclk,
    output logic             spi_sen_n,
    output logic             spi_sdata
);
    localparam int SETTLE_CYC = (CLK_HZ / 100 > 0) ? CLK_HZ / 100 : 1;
    localparam int ST_W       = $clog2(SETTLE_CYC + 1);
    localparam logic [ST_W-1:0] ST_LAST = ST_W'(SETTLE_CYC - 1);

    ld_state_e       state;
    frame_e          frm;
    logic            launched;
    logic            first_pend;
    logic [ST_W-1:0] st_cnt;
    latch_t          n_word;
    latch_t          c_word;
    latch_t          tx_word;
    split_t          split;
    logic            sh_load;
    logic            sh_fin;

    pll_ld_split i_split (
        .n_div (n_div),
        .res   (split)
    );

    always_comb begin
        case (frm)
            FRM_REF: tx_word = ref_word();
            FRM_CTL: tx_word = c_word;
            default: tx_word = n_word;
        endcase
    end

    assign sh_load = (state == LD_SEND) && !launched;

    pll_ld_shift #(.W(LATCH_W), .HALF_CYC(SCLK_HALF)) i_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (sh_load),
        .word  (tx_word),
        .sclk  (spi_sclk),
        .sen_n (spi_sen_n),
        .sdata (spi_sdata),
        .fin   (sh_fin)
    );

    pll_ld_sync i_lock (
        .clk  (clk),
        .rst  (rst),
        .din  (lock_pin),
        .dout (lock_sts)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= LD_IDLE;
            frm        <= FRM_REF;
            launched   <= 1'b0;
            first_pend <= 1'b1;
            st_cnt     <= '0;
            n_word     <= '0;
            c_word     <= '0;
            done       <= 1'b0;
            error      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                LD_IDLE: begin
                    if (start) begin
                        if (split.ok) begin
                            error    <= 1'b0;
                            n_word   <= ndiv_word(split.a, split.b, div2);
                            c_word   <= ctl_word(cp1, cp2);
                            frm      <= FRM_REF;
                            launched <= 1'b0;
                            state    <= LD_SEND;
                        end else begin
                            error <= 1'b1;
                            done  <= 1'b1;
                        end
                    end
                end
                LD_SEND: begin
                    if (!launched) begin
                        launched <= 1'b1;
                    end else if (sh_fin) begin
                        launched <= 1'b0;
                        case (frm)
                            FRM_REF: frm <= FRM_CTL;
                            FRM_CTL: begin
                                if (first_pend) begin
                                    st_cnt <= '0;
                                    state  <= LD_SETTLE;
                                end else begin
                                    frm <= FRM_NDIV;
                                end
                            end
                            default: begin
                                state <= LD_IDLE;
                                done  <= 1'b1;
                            end
                        endcase
                    end
                end
                LD_SETTLE: begin
                    if (st_cnt == ST_LAST) begin
                        first_pend <= 1'b0;
                        frm        <= FRM_NDIV;
                        state      <= LD_SEND;
                    end else begin
                        st_cnt <= st_cnt + 1'b1;
                    end
                end
                default: state <= LD_IDLE;
            endcase
        end
    end

    assign busy = (state != LD_IDLE);
endmodule

// File: rtl/pll_synth_loader_chk.sv
module pll_synth_loader_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic error,
    input logic lock_pin,
    input logic lock_sts,
    input logic spi_sclk,
    input logic spi_sen_n,
    input logic spi_sdata
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)           age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R5: the serial clock only pulses inside a frame
    a_r5_sclk_in_frame: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |-> !spi_sen_n);

    // R5: data does not move while the serial clock stays high
    a_r5_data_stable: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_sdata));

    // R8: done lasts exactly one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: a load ends only with done
    a_r8_busy_ends_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R1: a refused request never leaves a load running
    a_r1_err_idle: assert property (@(posedge clk) disable iff (rst)
        error |-> !busy);

    // R9: two-edge synchronizer latency
    a_r9_lock_delay: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (lock_sts == $past(lock_pin, 2)));
endmodule

bind pll_synth_loader pll_synth_loader_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .lock_pin  (lock_pin),
    .lock_sts  (lock_sts),
    .spi_sclk  (spi_sclk),
    .spi_sen_n (spi_sen_n),
    .spi_sdata (spi_sdata)
);

// File: tb/test_pll_synth_loader.sv
`timescale 1ns/1ps
module test_pll_synth_loader;
    localparam int CLK_HZ    = 3000;
    localparam int SETTLE    = CLK_HZ / 100;
    localparam int SCLK_HALF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] n_div = '0;
    logic        div2 = 1'b0;
    logic [2:0]  cp1 = '0;
    logic [2:0]  cp2 = '0;
    logic        lock_pin = 1'b0;
    logic        busy, done, error, lock_sts, spi_sclk, spi_sen_n, spi_sdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [23:0] fr_word [0:7];
    int          fr_bits [0:7];
    int          fr_fall [0:7];
    int          fr_rise [0:7];
    int          fcnt = 0;
    logic [23:0] cur = '0;
    int          curbits = 0;

    pll_synth_loader #(.CLK_HZ(CLK_HZ), .SCLK_HALF(SCLK_HALF)) i_pll_synth_loader (
        .clk(clk), .rst(rst), .start(start), .n_div(n_div), .div2(div2),
        .cp1(cp1), .cp2(cp2), .lock_pin(lock_pin), .busy(busy), .done(done),
        .error(error), .lock_sts(lock_sts), .spi_sclk(spi_sclk),
        .spi_sen_n(spi_sen_n), .spi_sdata(spi_sdata)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    always @(negedge spi_sen_n) begin
        cur = '0;
        curbits = 0;
        if (fcnt < 8) fr_fall[fcnt] = cyc;
    end
    always @(posedge spi_sclk) begin
        if (!spi_sen_n) begin
            cur = {cur[22:0], spi_sdata};
            curbits++;
        end
    end
    always @(posedge spi_sen_n) begin
        if (fcnt < 8) begin
            fr_word[fcnt] = cur;
            fr_bits[fcnt] = curbits;
            fr_rise[fcnt] = cyc;
        end
        fcnt++;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        lock_pin = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic wait_done(output bit got);
        got = 1'b0;
        for (int i = 0; i < 3000 && !got; i++) begin
            if (done) got = 1'b1;
            else begin
                @(posedge clk);
                #1;
            end
        end
    endtask

    task automatic do_load(input int n, input bit d2, input int c1, input int c2,
                           input int settle_mode, input bit mid_start);
        int b, a;
        bit got, feas;
        logic [23:0] en, ec;
        b = n / 8;
        a = n % 8;
        feas = (b >= a);
        en = 24'((d2 << 22) | (b << 8) | (a << 2) | 2);
        ec = 24'((c2 << 17) | (c1 << 14) | 'h924);
        fcnt = 0;
        n_div = 16'(n); div2 = d2; cp1 = 3'(c1); cp2 = 3'(c2);
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        if (feas) chk(busy == 1'b1, "R8 busy after start", longint'(busy), 1);
        if (mid_start && feas) begin
            repeat (10) @(posedge clk);
            #1 n_div = 16'(n + 100); div2 = ~d2; start = 1'b1;
            @(posedge clk);
            #1 start = 1'b0;
        end
        wait_done(got);
        chk(got, "R8 done seen", longint'(got), 1);
        @(posedge clk);
        #1;
        chk(done == 1'b0, "R8 done one cycle", longint'(done), 0);
        chk(busy == 1'b0, "R8 idle after done", longint'(busy), 0);
        if (!feas) begin
            repeat (10) @(posedge clk);
            #1;
            chk(error == 1'b1, "R1 error on refused", longint'(error), 1);
            chk(fcnt == 0, "R1 no frame when B<A", longint'(fcnt), 0);
        end else begin
            if (mid_start) begin
                repeat (60) @(posedge clk);
                #1;
            end
            chk(error == 1'b0, "R1 error clear on accept", longint'(error), 0);
            chk(fcnt == 3, "R5 three frames", longint'(fcnt), 3);
            if (fcnt == 3) begin
                for (int k = 0; k < 3; k++)
                    chk(fr_bits[k] == 24, "R5 frame length", longint'(fr_bits[k]), 24);
                chk(fr_word[0] == 24'h340041, "R2 ref frame", longint'(fr_word[0]), 'h340041);
                chk(fr_word[1] == ec, "R3 ctl frame", longint'(fr_word[1]), longint'(ec));
                chk(fr_word[2] == en, "R4 ndiv frame", longint'(fr_word[2]), longint'(en));
                chk(fr_fall[1] > fr_rise[0], "R6 gap ref-ctl", longint'(fr_fall[1] - fr_rise[0]), 1);
                chk(fr_fall[2] > fr_rise[1], "R6 gap ctl-ndiv", longint'(fr_fall[2] - fr_rise[1]), 1);
                if (settle_mode == 1)
                    chk(fr_fall[2] - fr_rise[1] >= SETTLE, "R7 first-load hold-off",
                        longint'(fr_fall[2] - fr_rise[1]), SETTLE);
                else if (settle_mode == 0)
                    chk(fr_fall[2] - fr_rise[1] < SETTLE, "R7 no hold-off later",
                        longint'(fr_fall[2] - fr_rise[1]), SETTLE - 1);
            end
        end
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R10 reset state
        chk(busy == 0 && done == 0 && error == 0, "R10 status after reset",
            longint'({busy, done, error}), 0);
        chk(spi_sen_n == 1 && spi_sclk == 0 && spi_sdata == 0, "R10 bus idle",
            longint'({spi_sen_n, spi_sclk, spi_sdata}), 4);
        chk(lock_sts == 0, "R10 lock low", longint'(lock_sts), 0);

        // R9 two-edge synchronizer
        lock_pin = 1'b1;
        @(posedge clk); #1;
        chk(lock_sts == 0, "R9 not after one edge", longint'(lock_sts), 0);
        @(posedge clk); #1;
        chk(lock_sts == 1, "R9 high after two edges", longint'(lock_sts), 1);
        lock_pin = 1'b0;
        repeat (2) @(posedge clk); #1;
        chk(lock_sts == 0, "R9 low after two edges", longint'(lock_sts), 0);

        // R1 refused request keeps the hold-off armed (R7)
        do_load(5, 1'b0, 7, 7, 2, 1'b0);
        do_load(100, 1'b1, 7, 7, 1, 1'b0);

        // sweep of divide values 0..255
        for (int n = 0; n < 256; n++)
            do_load(n, 1'(n & 1), (n >> 1) & 7, (n >> 5) & 7, 0, 1'b0);

        // largest divide values
        do_load(65535, 1'b1, 3, 5, 0, 1'b0);
        do_load(65528, 1'b0, 0, 0, 0, 1'b0);
        do_load(63, 1'b0, 1, 1, 0, 1'b0);

        // R8 start while busy is ignored
        do_load(200, 1'b0, 2, 6, 0, 1'b1);

        // R7 reset re-arms the hold-off
        do_reset();
        do_load(64, 1'b0, 4, 4, 1, 1'b0);
        do_load(72, 1'b1, 4, 4, 0, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule